// File: doc/BRIEF.md
# Table-Driven High-Radix Modular Reducer

This block computes the remainder of a dividend that is twice as wide as a fixed modulus. The modulus is expected to stay the same across many operations. Loading a modulus therefore builds, once, a small table that holds the modulus times every digit value of radix 2^DIGIT_K. Each dividend is then reduced one radix digit at a time. The reduction starts at the top digit position and walks down to position zero. At each position the block finds the largest table multiple that still fits under the running value at that position, and subtracts it. What is left after position zero is the remainder.

The modulus is loaded with a one-cycle `mod_load` pulse. `tbl_busy` is high while the table is built, one entry per clock. Dividends enter through a valid/ready handshake (`in_valid`, `in_ready`). `rem_done` pulses for one cycle when `rem_out` holds a new remainder. Only one operation is in flight at a time. The modulus must be non-zero.

The controller has five states:
- `ST_EMPTY`: after reset, no table exists.
- `ST_FILL`: the table is being built.
- `ST_IDLE`: ready for a dividend.
- `ST_STEP`: one digit position is processed per cycle.
- `ST_DONE`: the one-cycle result pulse.

Transitions:
- `ST_EMPTY` goes to `ST_FILL` on `mod_load`.
- `ST_FILL` goes to `ST_IDLE` when the last table entry is written.
- `ST_IDLE` goes to `ST_FILL` on `mod_load`. This takes priority over a pending dividend.
- `ST_IDLE` goes to `ST_STEP` when a dividend is accepted.
- `ST_STEP` stays in `ST_STEP` until position zero has been processed, then goes to `ST_DONE`.
- `ST_DONE` always returns to `ST_IDLE`.

Top module: `mr_reducer`

## Requirements
- R1: After reset, `tbl_busy`, `in_ready` and `rem_done` are all 0. A dividend offered before any modulus is loaded is never accepted, and `rem_done` stays 0.
- R2: A `mod_load` pulse taken in `ST_EMPTY` or `ST_IDLE` raises `tbl_busy` in the next cycle. `tbl_busy` stays high for exactly 2^DIGIT_K - 1 cycles. `in_ready` is 1 in the cycle after `tbl_busy` falls.
- R3: While `tbl_busy` is high, `in_ready` is 0 and a held `in_valid` is not accepted. The held dividend is accepted once the table is complete, and it yields the correct remainder.
- R4: For every non-zero modulus and every dividend of 2*MOD_W bits, `rem_out` equals the dividend modulo the modulus.
- R5: Every reported remainder is strictly less than the loaded modulus.
- R6: `rem_done` rises exactly DIV_W/DIGIT_K clock edges after the edge that accepts the dividend.
- R7: `rem_done` is high for a single cycle. `rem_out` keeps its value in the cycle after the pulse.
- R8: A `mod_load` pulse while an operation is running is ignored: `tbl_busy` stays 0 and the result uses the old modulus.
- R9: Loading a new modulus while in `ST_IDLE` rebuilds the table, and later results are taken modulo the new value.
- R10: `in_ready` is 0 for the whole time an operation is running.
- R11: The boundary cases are exact. A modulus of 1 gives 0. The all-ones modulus, a dividend of 0, the all-ones dividend, and dividends equal to the modulus and to the modulus minus one all give correct remainders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_load | input | 1 | One-cycle pulse: capture `mod_value` and build the table |
| mod_value | input | MOD_W | Modulus to load (non-zero) |
| tbl_busy | output | 1 | High while the multiple table is being built |
| in_valid | input | 1 | Dividend offered |
| in_ready | output | 1 | Block can accept a dividend this cycle |
| in_dividend | input | 2*MOD_W | Dividend |
| rem_done | output | 1 | One-cycle pulse: `rem_out` holds a new remainder |
| rem_out | output | MOD_W | Remainder of the last completed operation |

## Verification
A wrong table entry, or a wrong choice of digit at any position, leaves the result wrong. The result is then either not below the modulus or off by a multiple of the modulus at that position. This shows on `rem_out` at the very next `rem_done`, so the bench sweeps every modulus of a small build against many dividends, including those at the edges. A slip in the position counter or the controller shifts the `rem_done` pulse away from its fixed latency, or lets `in_ready` rise during a fill or a run. Both are seen within one operation.

// File: rtl/mr_pkg.sv
package mr_pkg;

    typedef enum logic [2:0] {
        ST_EMPTY,
        ST_FILL,
        ST_IDLE,
        ST_STEP,
        ST_DONE
    } mr_state_e;

endpackage

// File: rtl/mr_mult_table.sv
module mr_mult_table #(
    parameter int MOD_W   = 32,
    parameter int DIGIT_K = 4,
    localparam int TBL_N  = 1 << DIGIT_K,
    localparam int ENT_W  = MOD_W + DIGIT_K
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fill_start,
    input  logic [MOD_W-1:0]       modulus_in,
    output logic                   filling,
    output logic                   fill_last,
    output logic [MOD_W-1:0]       mod_q,
    output logic [TBL_N*ENT_W-1:0] entries_flat
);

    logic [ENT_W-1:0]   tbl [TBL_N];
    logic [ENT_W-1:0]   acc;
    logic [ENT_W-1:0]   acc_next;
    logic [DIGIT_K-1:0] idx;

    assign acc_next  = acc + {{DIGIT_K{1'b0}}, mod_q};
    assign fill_last = filling && (idx == DIGIT_K'(TBL_N - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filling <= 1'b0;
            idx     <= '0;
            acc     <= '0;
            mod_q   <= '0;
        end else if (fill_start) begin
            filling <= 1'b1;
            idx     <= DIGIT_K'(1);
            acc     <= '0;
            mod_q   <= modulus_in;
        end else if (filling) begin
            acc <= acc_next;
            idx <= idx + DIGIT_K'(1);
            if (fill_last) begin
                filling <= 1'b0;
            end
        end
    end

    assign tbl[0] = '0;

    generate
        for (genvar j = 1; j < TBL_N; j++) begin : g_entry
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tbl[j] <= '0;
                end else if (filling && (idx == DIGIT_K'(j))) begin
                    tbl[j] <= acc_next;
                end
            end
        end
        for (genvar j = 0; j < TBL_N; j++) begin : g_flat
            assign entries_flat[j*ENT_W +: ENT_W] = tbl[j];
        end
    endgenerate

    // R2, R9: when the fill ends, entry 1 holds the modulus itself.
    a_r2_first_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(filling) |-> (tbl[1] == {{DIGIT_K{1'b0}}, mod_q}));

    // R9: the top entry equals the modulus times the largest digit.
    a_r9_last_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(filling) |-> (tbl[TBL_N-1] ==
            ENT_W'(ENT_W'(mod_q) * ENT_W'(TBL_N - 1))));

endmodule

// File: rtl/mr_digit_sel.sv
module mr_digit_sel #(
    parameter int MOD_W   = 32,
    parameter int DIGIT_K = 4,
    localparam int TBL_N  = 1 << DIGIT_K,
    localparam int ENT_W  = MOD_W + DIGIT_K,
    localparam int DIV_W  = 2 * MOD_W
) (
    input  logic [TBL_N*ENT_W-1:0] entries_flat,
    input  logic [DIV_W-1:0]       window,
    output logic [DIGIT_K-1:0]     digit,
    output logic [ENT_W-1:0]       take
);

    logic [ENT_W-1:0] ent [TBL_N];
    logic [TBL_N-1:0] fits;

    generate
        for (genvar j = 0; j < TBL_N; j++) begin : g_cmp
            assign ent[j]  = entries_flat[j*ENT_W +: ENT_W];
            assign fits[j] = ({{(DIV_W-ENT_W){1'b0}}, ent[j]} <= window);
        end
    endgenerate

    always_comb begin
        digit = '0;
        for (int j = 0; j < TBL_N; j++) begin
            if (fits[j]) begin
                digit = DIGIT_K'(j);
            end
        end
    end

    assign take = ent[digit];

endmodule

// File: rtl/mr_reducer.sv
module mr_reducer #(
    parameter int MOD_W   = 32,
    parameter int DIGIT_K = 4,
    localparam int DIV_W  = 2 * MOD_W,
    localparam int TBL_N  = 1 << DIGIT_K,
    localparam int ENT_W  = MOD_W + DIGIT_K,
    localparam int NSTEP  = DIV_W / DIGIT_K,
    localparam int POS_W  = $clog2(NSTEP),
    localparam int SH_W   = $clog2(DIV_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_load,
    input  logic [MOD_W-1:0] mod_value,
    output logic             tbl_busy,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [DIV_W-1:0] in_dividend,
    output logic             rem_done,
    output logic [MOD_W-1:0] rem_out
);
    import mr_pkg::*;

    mr_state_e st, st_next;

    logic                   fill_start;
    logic                   tbl_filling;
    logic                   tbl_last;
    logic [MOD_W-1:0]       mod_q;
    logic [TBL_N*ENT_W-1:0] entries_flat;

    logic [DIV_W-1:0]   r_q;
    logic [POS_W-1:0]   pos_q;
    logic [MOD_W-1:0]   rem_q;
    logic [SH_W-1:0]    shamt;
    logic [DIV_W-1:0]   window;
    logic [DIV_W-1:0]   new_hi;
    logic [DIV_W-1:0]   low_mask;
    logic [DIV_W-1:0]   r_next;
    logic [DIGIT_K-1:0] digit;
    logic [ENT_W-1:0]   take;
    logic               accept;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_EMPTY;
        end else begin
            st <= st_next;
        end
    end

    // Next-state logic
    always_comb begin
        st_next = st;
        unique case (st)
            ST_EMPTY: if (mod_load) st_next = ST_FILL;
            ST_FILL:  if (tbl_last) st_next = ST_IDLE;
            ST_IDLE: begin
                if (mod_load)      st_next = ST_FILL;
                else if (in_valid) st_next = ST_STEP;
            end
            ST_STEP:  if (pos_q == '0) st_next = ST_DONE;
            ST_DONE:  st_next = ST_IDLE;
            default:  st_next = ST_EMPTY;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        tbl_busy   = (st == ST_FILL);
        in_ready   = (st == ST_IDLE) && !mod_load;
        rem_done   = (st == ST_DONE);
        fill_start = mod_load && ((st == ST_EMPTY) || (st == ST_IDLE));
    end

    assign accept  = in_valid && in_ready;
    assign rem_out = rem_q;

    mr_mult_table #(.MOD_W(MOD_W), .DIGIT_K(DIGIT_K)) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .fill_start   (fill_start),
        .modulus_in   (mod_value),
        .filling      (tbl_filling),
        .fill_last    (tbl_last),
        .mod_q        (mod_q),
        .entries_flat (entries_flat)
    );

    // One digit step of the datapath
    assign shamt    = SH_W'(pos_q) * SH_W'(DIGIT_K);
    assign window   = r_q >> shamt;
    assign low_mask = ~({DIV_W{1'b1}} << shamt);

    mr_digit_sel #(.MOD_W(MOD_W), .DIGIT_K(DIGIT_K)) u_sel (
        .entries_flat (entries_flat),
        .window       (window),
        .digit        (digit),
        .take         (take)
    );

    assign new_hi = window - {{(DIV_W-ENT_W){1'b0}}, take};
    assign r_next = (new_hi << shamt) | (r_q & low_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q   <= '0;
            pos_q <= '0;
            rem_q <= '0;
        end else if (accept) begin
            r_q   <= in_dividend;
            pos_q <= POS_W'(NSTEP - 1);
        end else if (st == ST_STEP) begin
            r_q   <= r_next;
            pos_q <= pos_q - POS_W'(1);
            if (pos_q == '0) begin
                rem_q <= r_next[MOD_W-1:0];
            end
        end
    end

    // R2: the fill state of the controller and the table fill run together.
    a_r2_fill_in_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL) |-> tbl_filling);

    // R4: the running value never grows during a digit step.
    a_r4_residue_nonincreasing: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STEP) |=> (r_q <= $past(r_q)));

    // R5: a reported remainder is below the modulus.
    a_r5_rem_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE) |-> (rem_q < mod_q));

    // R7: the done flag lasts one cycle.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rem_done |=> !rem_done);

    // R7: the remainder register changes only on the last digit step.
    a_r7_rem_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_STEP) |=> $stable(rem_q));

endmodule

// File: tb/sim_mr_reducer.sv
`timescale 1ns/1ps
module sim_mr_reducer;
    localparam int MW    = 8;
    localparam int KD    = 2;
    localparam int DW    = 2 * MW;
    localparam int NFILL = (1 << KD) - 1;
    localparam int NST   = DW / KD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mod_load = 1'b0;
    logic [MW-1:0] mod_value = '0;
    logic          tbl_busy;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_dividend = '0;
    logic          rem_done;
    logic [MW-1:0] rem_out;

    int errors = 0;
    int checks = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #2 clk = ~clk;

    mr_reducer #(.MOD_W(MW), .DIGIT_K(KD)) u0 (
        .clk(clk), .rst_n(rst_n), .mod_load(mod_load), .mod_value(mod_value),
        .tbl_busy(tbl_busy), .in_valid(in_valid), .in_ready(in_ready),
        .in_dividend(in_dividend), .rem_done(rem_done), .rem_out(rem_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Load a modulus; optionally hold a dividend on in_valid across the fill.
    task automatic load_mod(input int m, input bit hold, input logic [DW-1:0] hd);
        int n;
        @(negedge clk);
        mod_load  = 1'b1;
        mod_value = MW'(m);
        if (hold) begin
            in_valid    = 1'b1;
            in_dividend = hd;
        end
        @(negedge clk);
        mod_load = 1'b0;
        chk(tbl_busy == 1'b1, "R2 busy after load", int'(tbl_busy), 1);
        n = 0;
        while (tbl_busy) begin
            if (hold) begin
                chk(!in_ready && !rem_done, "R3 held off during fill", int'(in_ready), 0);
            end
            n++;
            @(negedge clk);
            if (n > 100) break;
        end
        chk(n == NFILL, "R2 fill length", n, NFILL);
        chk(in_ready == 1'b1, "R2 ready after fill", int'(in_ready), 1);
    endtask

    // One operation; optional stray load pulse while running.
    task automatic run_op(input logic [DW-1:0] d, input int m, input bit stray);
        int k;
        int exp;
        bit rdy_seen;
        bit busy_seen;
        logic [MW-1:0] held;
        exp = int'(d) % m;
        if (!in_valid) begin
            @(negedge clk);
            in_valid    = 1'b1;
            in_dividend = d;
        end
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid  = 1'b0;
        k         = 0;
        rdy_seen  = 1'b0;
        busy_seen = 1'b0;
        if (stray) begin
            mod_load  = 1'b1;
            mod_value = MW'(m == 1 ? 2 : m - 1);
        end
        while (!rem_done && k < 100) begin
            if (in_ready) rdy_seen = 1'b1;
            @(negedge clk);
            mod_load = 1'b0;
            if (tbl_busy) busy_seen = 1'b1;
            k++;
        end
        chk(k == NST, "R6 latency", k, NST);
        chk(!rdy_seen, "R10 ready low while running", int'(rdy_seen), 0);
        chk(int'(rem_out) == exp, "R4 remainder", int'(rem_out), exp);
        chk(int'(rem_out) < m, "R5 below modulus", int'(rem_out), m);
        if (stray) begin
            chk(!busy_seen, "R8 stray load no fill", int'(busy_seen), 0);
        end
        held = rem_out;
        @(negedge clk);
        chk(!rem_done, "R7 single pulse", int'(rem_done), 0);
        chk(rem_out == held, "R7 remainder held", int'(rem_out), int'(held));
    endtask

    function automatic logic [DW-1:0] next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg[31:16];
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tbl_busy, "R1 busy reset", int'(tbl_busy), 0);
        chk(!in_ready, "R1 ready reset", int'(in_ready), 0);
        chk(!rem_done, "R1 done reset", int'(rem_done), 0);
        in_valid    = 1'b1;
        in_dividend = 16'd1234;
        repeat (10) begin
            @(negedge clk);
            chk(!in_ready && !rem_done, "R1 no accept without table", int'(in_ready), 0);
        end
        // R3: dividend held across the first fill, then accepted
        load_mod(7, 1'b1, 16'd1234);
        run_op(16'd1234, 7, 1'b0);

        // R11: boundaries
        load_mod(1, 1'b0, '0);
        run_op(16'hFFFF, 1, 1'b0);
        run_op(16'd0, 1, 1'b0);
        load_mod(255, 1'b0, '0);
        run_op(16'hFFFF, 255, 1'b0);
        run_op(16'd255, 255, 1'b0);
        run_op(16'd254, 255, 1'b0);

        // R8: stray load during operation
        run_op(16'hBEEF, 255, 1'b1);
        run_op(16'h1357, 255, 1'b1);

        // R9 and R4: every modulus, edge and random dividends
        for (int m = 1; m < 256; m++) begin
            load_mod(m, 1'b0, '0);
            run_op(16'd0, m, 1'b0);
            run_op(16'hFFFF, m, 1'b0);
            run_op(DW'(m), m, 1'b0);
            run_op(DW'(m - 1), m, 1'b0);
            run_op(DW'(m * 200), m, 1'b0);
            run_op(DW'(m * 256 - 1), m, 1'b0);
            for (int i = 0; i < 8; i++) begin
                run_op(next_rand(), m, 1'b0);
            end
        end

        // R4: dense dividend sweeps for two moduli
        load_mod(3, 1'b0, '0);
        for (int d = 0; d < 1500; d++) begin
            run_op(DW'(d * 43), 3, 1'b0);
        end
        load_mod(200, 1'b0, '0);
        for (int d = 0; d < 1500; d++) begin
            run_op(DW'(d * 37 + 11), 200, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule